// File: doc/BRIEF.md
# Two-Half Hamming Parity Generator for Flash Transfers

This block computes a Hamming-style parity code while a 512-byte flash sector moves across the data port. Each byte that passes while calculation mode is active is folded into one of two accumulators. The first 256 bytes go to the lower half and the next 256 bytes go to the upper half. Each half keeps sixteen line-parity bits, derived from the byte's position inside the half, and six column-parity bits, derived from bit positions inside each byte.

A host drives the block through mode writes. One code clears the accumulators. A second code starts accumulation. A third code turns the data port into a readout port, which returns the six code bytes as three 16-bit words in an interleaved order. Software normally clears the block, performs a throw-away data read, enters calculation mode, moves the sector, and then reads the three words.

Top module: `sm_ecc_gen`

## Requirements
- R1: After reset the block is idle, both accumulators hold zero and the byte count is zero. Entering readout then returns 0x0000, 0x0003 and 0x0300.
- R2: A mode write of 0xF4 clears both accumulators and the byte count and leaves the block idle.
- R3: A mode write of 0xB4 enters calculation mode. Each cycle with `byte_vld` high in that mode folds `byte_in` into the active half and advances the byte count by one.
- R4: Let p be the XOR of all bits of a byte and i its 8-bit index within its half. For every index bit k, line-parity bit 2k+1 accumulates p when i[k]=1, and bit 2k accumulates p when i[k]=0.
- R5: For each of the 3 bit-position pairs k, column-parity bit 2k+1 accumulates the XOR of the byte bits j with j[k]=1, and bit 2k accumulates those with j[k]=0. The column byte of a half is {CP5..CP0, 2'b11}.
- R6: Bytes presented outside calculation mode change nothing. This covers the throw-away read after a clear. Any mode value other than 0xF4, 0xB4 or 0xD4 makes the block idle and keeps the accumulators, and a later 0xB4 resumes at the next byte index.
- R7: Bytes 0 to 255 of a transfer go to the lower half and bytes 256 to 511 go to the upper half, with no host action at the boundary.
- R8: Once 512 bytes have been counted, further bytes are ignored until the next 0xF4.
- R9: A mode write of 0xD4 enters readout with the word pointer at 0, and each `rd_en` advances the pointer 0→1→2→0. The words are as follows:
  - word 0 = {lower LP15..8, lower LP7..0}
  - word 1 = {upper LP7..0, lower column byte}
  - word 2 = {upper column byte, upper LP15..8}
- R10: Outside readout mode `rd_word` is 0x0000 and `rd_en` has no effect on the word pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 8 | Mode code written with `mode_wr` |
| byte_vld | input | 1 | A data byte crosses the port this cycle |
| byte_in | input | 8 | Data byte on the port |
| rd_en | input | 1 | Readout word consumed, advance the pointer |
| rd_word | output | 16 | Current readout word |

## Verification
The assertions check several rules on every cycle:
- a clear empties the count and both codes;
- the count never passes 512, and it steps by exactly one for each byte accepted in calculation mode;
- the codes stay frozen outside calculation mode and after the count is full;
- the word pointer stays within three words and ignores reads outside readout;
- the output is zero outside readout.

The actual parity values cannot be checked by a cycle-level property. These are the line and column mapping, the switch between halves at byte 256, the interleaved word packing, and resumption after a pause. Only the bench scenarios show them, by comparing the read words against an independently computed code.

// File: rtl/sm_ecc_pkg.sv
package sm_ecc_pkg;

    localparam int BYTE_W      = 8;
    localparam int HALF_BYTES  = 256;
    localparam int HALVES      = 2;
    localparam int IDX_W       = $clog2(HALF_BYTES);
    localparam int LP_W        = 2 * IDX_W;
    localparam int COL_PAIRS   = $clog2(BYTE_W);
    localparam int CP_W        = 2 * COL_PAIRS;
    localparam int TOTAL_BYTES = HALVES * HALF_BYTES;
    localparam int CNT_W       = $clog2(TOTAL_BYTES) + 1;
    localparam int WORD_W      = 16;
    localparam int NUM_WORDS   = 3;
    localparam int SEL_W       = 2;

    localparam logic [7:0] MODE_CLEAR  = 8'hF4;
    localparam logic [7:0] MODE_CALC   = 8'hB4;
    localparam logic [7:0] MODE_RESULT = 8'hD4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_RESULT = 2'd2
    } ecc_state_e;

    typedef struct packed {
        logic [LP_W-1:0] lp;
        logic [CP_W-1:0] cp;
    } half_code_t;

    // Selects which line-parity bits a byte at index idx contributes to
    function automatic logic [LP_W-1:0] line_mask(input logic [IDX_W-1:0] idx);
        logic [LP_W-1:0] m;
        for (int k = 0; k < IDX_W; k++) begin
            m[2*k+1] = idx[k];
            m[2*k]   = ~idx[k];
        end
        return m;
    endfunction

    // Column-parity contribution of one byte
    function automatic logic [CP_W-1:0] col_parity(input logic [BYTE_W-1:0] b);
        logic [CP_W-1:0] c;
        for (int k = 0; k < COL_PAIRS; k++) begin
            logic odd_g;
            logic even_g;
            odd_g  = 1'b0;
            even_g = 1'b0;
            for (int j = 0; j < BYTE_W; j++) begin
                if (((j >> k) & 1) == 1) odd_g = odd_g ^ b[j];
                else                     even_g = even_g ^ b[j];
            end
            c[2*k+1] = odd_g;
            c[2*k]   = even_g;
        end
        return c;
    endfunction

endpackage

// File: rtl/sm_ecc_mode_ctl.sv
module sm_ecc_mode_ctl
    import sm_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr,
    input  logic [7:0]       mode_val,
    input  logic             rd_en,
    output ecc_state_e       state,
    output logic             clr,
    output logic [SEL_W-1:0] rd_sel
);

    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_WORDS - 1);

    assign clr = mode_wr && (mode_val == MODE_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else if (mode_wr) begin
            case (mode_val)
                MODE_CALC:   state <= ST_CALC;
                MODE_RESULT: state <= ST_RESULT;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sel <= '0;
        end else if (mode_wr) begin
            if (mode_val == MODE_RESULT) rd_sel <= '0;
        end else if (rd_en && state == ST_RESULT) begin
            rd_sel <= (rd_sel == LAST_SEL) ? '0 : rd_sel + 1'b1;
        end
    end

endmodule

// File: rtl/sm_ecc_half_acc.sv
module sm_ecc_half_acc
    import sm_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] byte_in,
    output half_code_t        code
);

    logic            byte_par;
    logic [LP_W-1:0] lp_delta;
    logic [CP_W-1:0] cp_delta;

    always_comb begin
        byte_par = ^byte_in;
        lp_delta = line_mask(idx) & {LP_W{byte_par}};
        cp_delta = col_parity(byte_in);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code <= '0;
        end else if (take) begin
            code.lp <= code.lp ^ lp_delta;
            code.cp <= code.cp ^ cp_delta;
        end
    end

endmodule

// File: rtl/sm_ecc_pack.sv
module sm_ecc_pack
    import sm_ecc_pkg::*;
(
    input  half_code_t [HALVES-1:0] codes,
    input  logic                    in_result,
    input  logic [SEL_W-1:0]        rd_sel,
    output logic [WORD_W-1:0]       rd_word
);

    localparam int HB = LP_W / 2;

    logic [BYTE_W-1:0] col_lo;
    logic [BYTE_W-1:0] col_hi;

    always_comb begin
        col_lo = {codes[0].cp, 2'b11};
        col_hi = {codes[1].cp, 2'b11};
        rd_word = '0;
        if (in_result) begin
            case (rd_sel)
                2'd0:    rd_word = codes[0].lp;
                2'd1:    rd_word = {codes[1].lp[HB-1:0], col_lo};
                2'd2:    rd_word = {col_hi, codes[1].lp[LP_W-1:HB]};
                default: rd_word = '0;
            endcase
        end
    end

endmodule

// File: rtl/sm_ecc_gen.sv
module sm_ecc_gen
    import sm_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [7:0]        mode_val,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word
);

    ecc_state_e              state;
    logic                    clr;
    logic [SEL_W-1:0]        rd_sel;
    logic [CNT_W-1:0]        byte_cnt;
    logic                    take;
    half_code_t [HALVES-1:0] codes;

    sm_ecc_mode_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .mode_wr  (mode_wr),
        .mode_val (mode_val),
        .rd_en    (rd_en),
        .state    (state),
        .clr      (clr),
        .rd_sel   (rd_sel)
    );

    assign take = (state == ST_CALC) && byte_vld && (byte_cnt < CNT_W'(TOTAL_BYTES));

    always_ff @(posedge clk) begin
        if (rst || clr)  byte_cnt <= '0;
        else if (take)   byte_cnt <= byte_cnt + 1'b1;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic take_h;
        assign take_h = take && (int'(byte_cnt[CNT_W-1:IDX_W]) == h);
        sm_ecc_half_acc u_acc (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .take    (take_h),
            .idx     (byte_cnt[IDX_W-1:0]),
            .byte_in (byte_in),
            .code    (codes[h])
        );
    end

    sm_ecc_pack u_pack (
        .codes     (codes),
        .in_result (state == ST_RESULT),
        .rd_sel    (rd_sel),
        .rd_word   (rd_word)
    );

endmodule

// File: rtl/sm_ecc_gen_chk.sv
module sm_ecc_gen_chk
    import sm_ecc_pkg::*;
(
    input logic                                clk,
    input logic                                rst,
    input logic                                mode_wr,
    input logic [7:0]                          mode_val,
    input logic                                byte_vld,
    input logic                                rd_en,
    input logic [WORD_W-1:0]                   rd_word,
    input ecc_state_e                          state,
    input logic [CNT_W-1:0]                    cnt,
    input logic [SEL_W-1:0]                    rd_sel,
    input logic [HALVES*$bits(half_code_t)-1:0] codes
);

    logic is_clear;
    assign is_clear = mode_wr && (mode_val == MODE_CLEAR);

    a_r2_clear_empties: assert property (@(posedge clk) disable iff (rst)
        is_clear |=> (cnt == '0) && (codes == '0));

    a_r3_count_steps: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CALC && byte_vld && cnt < CNT_W'(TOTAL_BYTES) && !is_clear)
        |=> cnt == $past(cnt) + 1'b1);

    a_r6_frozen_outside_calc: assert property (@(posedge clk) disable iff (rst)
        (state != ST_CALC && !is_clear) |=> $stable(cnt) && $stable(codes));

    a_r8_count_capped: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(TOTAL_BYTES));

    a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(TOTAL_BYTES) && !is_clear) |=> $stable(codes));

    a_r9_sel_range: assert property (@(posedge clk) disable iff (rst)
        rd_sel < SEL_W'(NUM_WORDS));

    a_r10_rd_ignored: assert property (@(posedge clk) disable iff (rst)
        (rd_en && state != ST_RESULT && !mode_wr) |=> $stable(rd_sel));

    a_r10_quiet_output: assert property (@(posedge clk) disable iff (rst)
        state != ST_RESULT |-> rd_word == '0);

endmodule

bind sm_ecc_gen sm_ecc_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_wr  (mode_wr),
    .mode_val (mode_val),
    .byte_vld (byte_vld),
    .rd_en    (rd_en),
    .rd_word  (rd_word),
    .state    (state),
    .cnt      (byte_cnt),
    .rd_sel   (rd_sel),
    .codes    (codes)
);

// File: tb/sm_ecc_gen_tb.sv
`timescale 1ns/1ps
module sm_ecc_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_wr;
    logic [7:0]  mode_val;
    logic        byte_vld;
    logic [7:0]  byte_in;
    logic        rd_en;
    logic [15:0] rd_word;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model state
    logic [15:0] m_lp [2];
    logic [5:0]  m_cp [2];
    int          m_cnt;
    bit          m_calc;

    always #4 clk = ~clk;

    sm_ecc_gen u_dut (
        .clk      (clk),
        .rst      (rst),
        .mode_wr  (mode_wr),
        .mode_val (mode_val),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .rd_en    (rd_en),
        .rd_word  (rd_word)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int h = 0; h < 2; h++) begin
            m_lp[h] = '0;
            m_cp[h] = '0;
        end
        m_cnt = 0;
    endtask

    function automatic logic [15:0] model_word(input int k);
        logic [7:0] c0;
        logic [7:0] c1;
        c0 = {m_cp[0], 2'b11};
        c1 = {m_cp[1], 2'b11};
        case (k)
            0:       return m_lp[0];
            1:       return {m_lp[1][7:0], c0};
            default: return {c1, m_lp[1][15:8]};
        endcase
    endfunction

    task automatic set_mode(input logic [7:0] v);
        @(negedge clk);
        mode_wr  = 1'b1;
        mode_val = v;
        @(negedge clk);
        mode_wr  = 1'b0;
        if (v == 8'hF4) begin
            model_clear();
            m_calc = 1'b0;
        end else begin
            m_calc = (v == 8'hB4);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
        if (m_calc && m_cnt < 512) begin
            int h;
            int i;
            h = m_cnt / 256;
            i = m_cnt % 256;
            for (int k = 0; k < 8; k++) begin
                if (((i >> k) & 1) == 1) m_lp[h][2*k+1] ^= ^b;
                else                     m_lp[h][2*k]   ^= ^b;
            end
            for (int j = 0; j < 8; j++) begin
                for (int k = 0; k < 3; k++) begin
                    if (((j >> k) & 1) == 1) m_cp[h][2*k+1] ^= b[j];
                    else                     m_cp[h][2*k]   ^= b[j];
                end
            end
            m_cnt++;
        end
    endtask

    task automatic pulse_rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // enters readout and compares all three words with the model
    task automatic read_all(input string tag);
        set_mode(8'hD4);
        for (int k = 0; k < 3; k++) begin
            check(rd_word === model_word(k), tag, rd_word, model_word(k));
            pulse_rd();
        end
    endtask

    task automatic t_reset();
        check(rd_word === 16'h0000, "R10 output zero after reset", rd_word, 16'h0000);
        set_mode(8'hD4);
        check(rd_word === 16'h0000, "R1 reset word0", rd_word, 16'h0000);
        pulse_rd();
        check(rd_word === 16'h0003, "R1 reset word1", rd_word, 16'h0003);
        pulse_rd();
        check(rd_word === 16'h0300, "R1 reset word2", rd_word, 16'h0300);
        pulse_rd();
        check(rd_word === 16'h0000, "R9 pointer wraps to word0", rd_word, 16'h0000);
    endtask

    task automatic t_single_byte();
        set_mode(8'hF4);
        push(8'h11);                 // throw-away read, must be ignored (R6)
        set_mode(8'hB4);
        push(8'h01);
        set_mode(8'hD4);
        check(rd_word === 16'h5555, "R4 index0 line parity", rd_word, 16'h5555);
        pulse_rd();
        check(rd_word === 16'h0057, "R5 column byte bit0, R6 dummy ignored", rd_word, 16'h0057);
        pulse_rd();
        check(rd_word === 16'h0300, "R9 word2 single byte", rd_word, 16'h0300);
        pulse_rd();
    endtask

    task automatic t_half_boundary();
        set_mode(8'hF4);
        set_mode(8'hB4);
        for (int i = 0; i < 256; i++) push(8'h00);
        push(8'h80);
        set_mode(8'hD4);
        check(rd_word === 16'h0000, "R7 lower half untouched", rd_word, 16'h0000);
        pulse_rd();
        check(rd_word === 16'h5503, "R7 byte 256 in upper half", rd_word, 16'h5503);
        pulse_rd();
        check(rd_word === 16'hAB55, "R5 bit7 odd columns upper", rd_word, 16'hAB55);
        pulse_rd();
    endtask

    task automatic t_full_sector();
        set_mode(8'hF4);
        set_mode(8'hB4);
        for (int i = 0; i < 512; i++) push(8'((i * 37 + 5) ^ (i >> 3)));
        read_all("R3 R4 R5 full sector");
        set_mode(8'hB4);
        for (int i = 0; i < 20; i++) push(8'(i * 13 + 1));
        read_all("R8 bytes past 512 ignored");
    endtask

    task automatic t_pause_resume();
        set_mode(8'hF4);
        set_mode(8'hB4);
        for (int i = 0; i < 10; i++) push(8'(i * 29 + 7));
        set_mode(8'h94);
        for (int i = 0; i < 5; i++) push(8'hFF);
        pulse_rd();
        check(rd_word === 16'h0000, "R10 idle output zero", rd_word, 16'h0000);
        set_mode(8'hB4);
        for (int i = 0; i < 10; i++) push(8'(i * 53 + 3));
        read_all("R6 pause and resume");
        set_mode(8'hD4);
        pulse_rd();
        set_mode(8'hD4);
        check(rd_word === model_word(0), "R9 readout restarts at word0", rd_word, model_word(0));
        set_mode(8'hF4);
        read_all("R2 clear empties codes");
    endtask

    initial begin
        rst      = 1'b1;
        mode_wr  = 1'b0;
        mode_val = 8'h00;
        byte_vld = 1'b0;
        byte_in  = 8'h00;
        rd_en    = 1'b0;
        m_calc   = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_byte();
        t_half_boundary();
        t_full_sector();
        t_pause_resume();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule